// File: doc/BRIEF.md
# Write Stream Locality Detector

This block sits in front of a flash write path and decides, page by page, whether the incoming writes belong to a sequential stream or to random traffic. The newest page arrives on a valid/ready intake port. The page accepted before it waits in a one-entry holding register. When a new page is accepted, the block compares its logical address with the held page's address. The controller then routes the held page to one of three places, based on that comparison and on its mode (Random, Judge or Sequential):

- the sequential buffer,
- the random buffer,
- straight out as a sequential flash write.

A full sequential buffer leaves as an in-order burst on the sequential write port. The random buffer leaves as a batch on the dispatch port. The downstream channel logic spreads that batch across its parallel channels. The batch size follows the number of channels that are currently usable, which arrives on an input.

A read lookup port searches the holding register, the pending direct write and both buffers. It answers one cycle later with hit/miss and data, so a read of recently written data can skip the mapping lookup.

Top module: `wsl_detector`

## Requirements
- R1: After reset the mode is Random, the holding register is empty, `in_ready` is 1 and `seq_valid`, `rnd_valid` and `rd_ack` are 0. The first page accepted after reset only fills the holding register and produces no output.
- R2: In Random mode, a new page whose address is not the held address plus one appends the held page to the random buffer. Once the buffer holds at least the threshold number of entries, the buffer is sent on the random port, oldest first, one entry per handshake, and then emptied.
- R3: Two addresses are consecutive when the new address minus the held address, taken modulo 2^AW, equals 1, so 16'hFFFF followed by 16'h0000 is consecutive. In Random mode a consecutive page moves the held page into the sequential buffer and selects Judge mode, with no output.
- R4: In Judge mode a consecutive page appends the held page to the sequential buffer. If that makes SDEPTH entries, all entries go out on the sequential port, oldest first, and the mode becomes Sequential.
- R5: In Judge mode a non-consecutive page appends the held page to the sequential buffer and selects Random mode. The random port then sends every random-buffer entry and after them every sequential-buffer entry, oldest first within each, and both buffers are emptied.
- R6: In Sequential mode a consecutive page sends the held page alone on the sequential port.
- R7: In Sequential mode a non-consecutive page sends the held page alone on the sequential port and selects Random mode.
- R8: `in_ready` is 0 whenever `seq_valid` or `rnd_valid` is 1. Intake resumes only when no write is pending on either port.
- R9: A cycle with `rd_req` high gives `rd_ack` = 1 in the next cycle. On a hit, `rd_hit` is 1 and `rd_data` holds the data of the newest matching entry, searched in this order: holding register, pending direct write, sequential buffer, random buffer. On a miss, `rd_hit` and `rd_data` are 0.
- R10: The threshold is `chan_count`, except that 0 is treated as 1 and any value above RDEPTH is treated as RDEPTH.
- R11: While `seq_valid` or `rnd_valid` is high and the matching ready is low, that port keeps its valid, address and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | New page offered |
| in_ready | output | 1 | New page can be taken |
| in_addr | input | AW | Logical page address of new page |
| in_data | input | DW | Data word of new page |
| chan_count | input | CHW | Number of usable channels |
| seq_valid | output | 1 | Sequential write pending |
| seq_ready | input | 1 | Sequential write taken |
| seq_addr | output | AW | Sequential write address |
| seq_data | output | DW | Sequential write data |
| rnd_valid | output | 1 | Random dispatch entry pending |
| rnd_ready | input | 1 | Random dispatch entry taken |
| rnd_addr | output | AW | Random dispatch address |
| rnd_data | output | DW | Random dispatch data |
| rd_req | input | 1 | Read lookup request |
| rd_addr | input | AW | Read lookup address |
| rd_ack | output | 1 | Lookup answer valid |
| rd_hit | output | 1 | Lookup found buffered data |
| rd_data | output | DW | Data of the newest match |

## Verification
A wrong mode does not show up when the page is accepted. It shows up when the next page is accepted: the held page then appears on the wrong port, or fails to appear at all. The scoreboard catches it at the first handshake, within a cycle or two of that next acceptance.

A wrong buffer count or index shows up as a burst or batch of the wrong length or in the wrong order. It can also show up as a lookup answer that is stale or missing.

Intake or hold faults show within one cycle, as a page accepted during a pending write or as a port that changes while its ready is low.

// File: rtl/wsl_pkg.sv
package wsl_pkg;
    typedef enum logic [1:0] {
        MODE_RND = 2'd0,
        MODE_JDG = 2'd1,
        MODE_SEQ = 2'd2
    } mode_e;
endpackage

// File: rtl/wsl_buf.sv
module wsl_buf #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [AW-1:0]   push_addr,
    input  logic [DW-1:0]   push_data,
    input  logic            clear,
    input  logic [IW-1:0]   rd_idx,
    output logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic [CNTW-1:0] count,
    input  logic [AW-1:0]   look_addr,
    output logic            look_hit,
    output logic [DW-1:0]   look_data
);
    logic [AW-1:0]   addr_mem [DEPTH];
    logic [DW-1:0]   data_mem [DEPTH];
    logic [CNTW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (push && (count_q < CNTW'(DEPTH))) begin
            count_q <= count_q + CNTW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clear && (count_q < CNTW'(DEPTH))) begin
            addr_mem[count_q[IW-1:0]] <= push_addr;
            data_mem[count_q[IW-1:0]] <= push_data;
        end
    end

    assign count   = count_q;
    assign rd_addr = addr_mem[rd_idx];
    assign rd_data = data_mem[rd_idx];

    // later entries override earlier ones: the newest match wins
    always_comb begin
        look_hit  = 1'b0;
        look_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if ((CNTW'(i) < count_q) && (addr_mem[i] == look_addr)) begin
                look_hit  = 1'b1;
                look_data = data_mem[i];
            end
        end
    end
endmodule

// File: rtl/wsl_thresh.sv
module wsl_thresh #(
    parameter int CHW    = 4,
    parameter int RDEPTH = 8,
    localparam int RCW   = $clog2(RDEPTH + 1)
) (
    input  logic [CHW-1:0] chan_count,
    output logic [RCW-1:0] thr
);
    logic [31:0] chan_w;

    always_comb begin
        chan_w = 32'(chan_count);
        if (chan_w == 32'd0) begin
            thr = RCW'(1);
        end else if (chan_w > 32'(RDEPTH)) begin
            thr = RCW'(RDEPTH);
        end else begin
            thr = RCW'(chan_w);
        end
    end
endmodule

// File: rtl/wsl_detector.sv
module wsl_detector
    import wsl_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 32,
    parameter int SDEPTH = 8,
    parameter int RDEPTH = 8,
    parameter int CHW    = 4,
    localparam int SIW   = $clog2(SDEPTH),
    localparam int RIW   = $clog2(RDEPTH),
    localparam int SCW   = $clog2(SDEPTH + 1),
    localparam int RCW   = $clog2(RDEPTH + 1),
    localparam int XIW   = (SIW > RIW) ? SIW : RIW,
    localparam int XCW   = XIW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [AW-1:0]  in_addr,
    input  logic [DW-1:0]  in_data,
    input  logic [CHW-1:0] chan_count,
    output logic           seq_valid,
    input  logic           seq_ready,
    output logic [AW-1:0]  seq_addr,
    output logic [DW-1:0]  seq_data,
    output logic           rnd_valid,
    input  logic           rnd_ready,
    output logic [AW-1:0]  rnd_addr,
    output logic [DW-1:0]  rnd_data,
    input  logic           rd_req,
    input  logic [AW-1:0]  rd_addr,
    output logic           rd_ack,
    output logic           rd_hit,
    output logic [DW-1:0]  rd_data
);
    typedef struct packed {
        mode_e          mode;
        logic           prev_vld;
        logic [AW-1:0]  prev_addr;
        logic [DW-1:0]  prev_data;
        logic           dir_vld;
        logic [AW-1:0]  dir_addr;
        logic [DW-1:0]  dir_data;
        logic           sfl;
        logic [SIW-1:0] sidx;
        logic           rdr;
        logic           rph;
        logic           rseq;
        logic [XIW-1:0] ridx;
        logic           rd_ack;
        logic           rd_hit;
        logic [DW-1:0]  rd_data;
    } st_t;

    st_t st_d, st_q;

    logic           s_push, s_clear, r_push, r_clear;
    logic [SIW-1:0] s_rd_idx;
    logic [RIW-1:0] r_rd_idx;
    logic [AW-1:0]  s_rd_addr, r_rd_addr;
    logic [DW-1:0]  s_rd_data, r_rd_data;
    logic [SCW-1:0] s_count;
    logic [RCW-1:0] r_count;
    logic           s_hit, r_hit;
    logic [DW-1:0]  s_hit_data, r_hit_data;
    logic [RCW-1:0] thr;

    wsl_buf #(.DEPTH(SDEPTH), .AW(AW), .DW(DW)) u_sbuf (
        .clk(clk), .rst_n(rst_n),
        .push(s_push), .push_addr(st_q.prev_addr), .push_data(st_q.prev_data),
        .clear(s_clear), .rd_idx(s_rd_idx), .rd_addr(s_rd_addr), .rd_data(s_rd_data),
        .count(s_count), .look_addr(rd_addr), .look_hit(s_hit), .look_data(s_hit_data)
    );

    wsl_buf #(.DEPTH(RDEPTH), .AW(AW), .DW(DW)) u_rbuf (
        .clk(clk), .rst_n(rst_n),
        .push(r_push), .push_addr(st_q.prev_addr), .push_data(st_q.prev_data),
        .clear(r_clear), .rd_idx(r_rd_idx), .rd_addr(r_rd_addr), .rd_data(r_rd_data),
        .count(r_count), .look_addr(rd_addr), .look_hit(r_hit), .look_data(r_hit_data)
    );

    wsl_thresh #(.CHW(CHW), .RDEPTH(RDEPTH)) u_thr (
        .chan_count(chan_count), .thr(thr)
    );

    logic busy, accept, consec;

    assign busy      = st_q.sfl | st_q.rdr | st_q.dir_vld;
    assign in_ready  = !busy;
    assign accept    = in_valid && !busy;
    assign consec    = ((in_addr - st_q.prev_addr) == AW'(1));

    assign s_rd_idx  = st_q.sfl ? st_q.sidx : st_q.ridx[SIW-1:0];
    assign r_rd_idx  = st_q.ridx[RIW-1:0];

    assign seq_valid = st_q.sfl | st_q.dir_vld;
    assign seq_addr  = st_q.sfl ? s_rd_addr : st_q.dir_addr;
    assign seq_data  = st_q.sfl ? s_rd_data : st_q.dir_data;
    assign rnd_valid = st_q.rdr;
    assign rnd_addr  = st_q.rph ? s_rd_addr : r_rd_addr;
    assign rnd_data  = st_q.rph ? s_rd_data : r_rd_data;

    assign rd_ack    = st_q.rd_ack;
    assign rd_hit    = st_q.rd_hit;
    assign rd_data   = st_q.rd_data;

    always_comb begin
        st_d    = st_q;
        s_push  = 1'b0;
        r_push  = 1'b0;
        s_clear = 1'b0;
        r_clear = 1'b0;

        // page intake and routing of the held page
        if (accept) begin
            if (st_q.prev_vld) begin
                unique case (st_q.mode)
                    MODE_RND: begin
                        if (consec) begin
                            s_push     = 1'b1;
                            st_d.mode  = MODE_JDG;
                        end else begin
                            r_push = 1'b1;
                            if ((r_count + RCW'(1)) >= thr) begin
                                st_d.rdr  = 1'b1;
                                st_d.rph  = 1'b0;
                                st_d.rseq = 1'b0;
                                st_d.ridx = '0;
                            end
                        end
                    end
                    MODE_JDG: begin
                        s_push = 1'b1;
                        if (consec) begin
                            if ((s_count + SCW'(1)) == SCW'(SDEPTH)) begin
                                st_d.sfl  = 1'b1;
                                st_d.sidx = '0;
                                st_d.mode = MODE_SEQ;
                            end
                        end else begin
                            st_d.rdr  = 1'b1;
                            st_d.rseq = 1'b1;
                            st_d.rph  = (r_count == '0);
                            st_d.ridx = '0;
                            st_d.mode = MODE_RND;
                        end
                    end
                    MODE_SEQ: begin
                        st_d.dir_vld  = 1'b1;
                        st_d.dir_addr = st_q.prev_addr;
                        st_d.dir_data = st_q.prev_data;
                        if (!consec) begin
                            st_d.mode = MODE_RND;
                        end
                    end
                    default: st_d.mode = MODE_RND;
                endcase
            end
            st_d.prev_vld  = 1'b1;
            st_d.prev_addr = in_addr;
            st_d.prev_data = in_data;
        end

        // sequential port: burst flush or single direct page
        if (seq_ready) begin
            if (st_q.sfl) begin
                if ((SCW'(st_q.sidx) + SCW'(1)) == s_count) begin
                    st_d.sfl  = 1'b0;
                    st_d.sidx = '0;
                    s_clear   = 1'b1;
                end else begin
                    st_d.sidx = st_q.sidx + SIW'(1);
                end
            end else if (st_q.dir_vld) begin
                st_d.dir_vld = 1'b0;
            end
        end

        // random dispatch: random entries, then optionally sequential ones
        if (st_q.rdr && rnd_ready) begin
            if (!st_q.rph) begin
                if (({1'b0, st_q.ridx} + XCW'(1)) == XCW'(r_count)) begin
                    r_clear   = 1'b1;
                    st_d.ridx = '0;
                    if (st_q.rseq) begin
                        st_d.rph = 1'b1;
                    end else begin
                        st_d.rdr = 1'b0;
                    end
                end else begin
                    st_d.ridx = st_q.ridx + XIW'(1);
                end
            end else begin
                if (({1'b0, st_q.ridx} + XCW'(1)) == XCW'(s_count)) begin
                    s_clear   = 1'b1;
                    st_d.rdr  = 1'b0;
                    st_d.rph  = 1'b0;
                    st_d.rseq = 1'b0;
                    st_d.ridx = '0;
                end else begin
                    st_d.ridx = st_q.ridx + XIW'(1);
                end
            end
        end

        // read lookup, newest storage first
        st_d.rd_ack  = rd_req;
        st_d.rd_hit  = 1'b0;
        st_d.rd_data = '0;
        if (rd_req) begin
            if (st_q.prev_vld && (st_q.prev_addr == rd_addr)) begin
                st_d.rd_hit  = 1'b1;
                st_d.rd_data = st_q.prev_data;
            end else if (st_q.dir_vld && (st_q.dir_addr == rd_addr)) begin
                st_d.rd_hit  = 1'b1;
                st_d.rd_data = st_q.dir_data;
            end else if (s_hit) begin
                st_d.rd_hit  = 1'b1;
                st_d.rd_data = s_hit_data;
            end else if (r_hit) begin
                st_d.rd_hit  = 1'b1;
                st_d.rd_data = r_hit_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MODE_RND;
        end else begin
            st_q      <= st_d;
        end
    end
endmodule

// File: rtl/wsl_detector_chk.sv
module wsl_detector_chk #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          seq_valid,
    input logic          seq_ready,
    input logic [AW-1:0] seq_addr,
    input logic [DW-1:0] seq_data,
    input logic          rnd_valid,
    input logic          rnd_ready,
    input logic [AW-1:0] rnd_addr,
    input logic [DW-1:0] rnd_data,
    input logic          rd_req,
    input logic          rd_ack,
    input logic          rd_hit
);
    AST_INTAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!seq_valid && !rnd_valid)); // R8

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_valid && rnd_valid)); // R8

    AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_valid && !seq_ready) |=> (seq_valid && $stable(seq_addr) && $stable(seq_data))); // R11

    AST_RND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_valid && !rnd_ready) |=> (rnd_valid && $stable(rnd_addr) && $stable(rnd_data))); // R11

    AST_RD_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_ack); // R9

    AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!rd_ack && !rd_hit)); // R9
endmodule

bind wsl_detector wsl_detector_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/wsl_detector_test.sv
`timescale 1ns/1ps
module wsl_detector_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic [3:0]  chan_count = 4'd4;
    logic        seq_valid, rnd_valid;
    logic        seq_ready = 1'b1, rnd_ready = 1'b1;
    logic [15:0] seq_addr, rnd_addr;
    logic [31:0] seq_data, rnd_data;
    logic        rd_req = 1'b0;
    logic [15:0] rd_addr = '0;
    logic        rd_ack, rd_hit;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    wsl_detector uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
        .chan_count(chan_count),
        .seq_valid(seq_valid), .seq_ready(seq_ready), .seq_addr(seq_addr), .seq_data(seq_data),
        .rnd_valid(rnd_valid), .rnd_ready(rnd_ready), .rnd_addr(rnd_addr), .rnd_data(rnd_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_hit(rd_hit), .rd_data(rd_data)
    );

    // scoreboard queues
    logic [47:0] exp_seq[$];
    string       tag_seq[$];
    logic [47:0] exp_rnd[$];
    string       tag_rnd[$];

    // reference model state
    int          m_mode = 0; // 0 random, 1 judge, 2 sequential
    bit          m_pv = 0;
    logic [15:0] m_pa;
    logic [31:0] m_pd;
    logic [47:0] m_sq[$];
    logic [47:0] m_rq[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int thr_of(input logic [3:0] c);
        if (c == 0) return 1;      // R10
        if (c > 8) return 8;       // R10
        return int'(c);
    endfunction

    task automatic model_accept(input logic [15:0] a, input logic [31:0] d);
        logic [47:0] prv;
        bit cons;
        if (!m_pv) begin          // R1: first page only loads
            m_pv = 1; m_pa = a; m_pd = d;
            return;
        end
        cons = (16'(a - m_pa) == 16'd1); // R3 modulo compare
        prv = {m_pa, m_pd};
        case (m_mode)
            0: begin
                if (cons) begin
                    m_sq.push_back(prv); m_mode = 1;      // R3
                end else begin
                    m_rq.push_back(prv);                  // R2
                    if (m_rq.size() >= thr_of(chan_count)) begin
                        foreach (m_rq[i]) begin exp_rnd.push_back(m_rq[i]); tag_rnd.push_back("R2"); end
                        m_rq.delete();
                    end
                end
            end
            1: begin
                m_sq.push_back(prv);
                if (cons) begin
                    if (m_sq.size() == 8) begin           // R4
                        foreach (m_sq[i]) begin exp_seq.push_back(m_sq[i]); tag_seq.push_back("R4"); end
                        m_sq.delete(); m_mode = 2;
                    end
                end else begin                            // R5
                    foreach (m_rq[i]) begin exp_rnd.push_back(m_rq[i]); tag_rnd.push_back("R5"); end
                    foreach (m_sq[i]) begin exp_rnd.push_back(m_sq[i]); tag_rnd.push_back("R5"); end
                    m_rq.delete(); m_sq.delete(); m_mode = 0;
                end
            end
            default: begin
                exp_seq.push_back(prv);
                tag_seq.push_back(cons ? "R6" : "R7");
                if (!cons) m_mode = 0;
            end
        endcase
        m_pa = a; m_pd = d;
    endtask

    function automatic logic [32:0] mlook(input logic [15:0] a);
        if (m_pv && m_pa == a) return {1'b1, m_pd};
        for (int i = m_sq.size() - 1; i >= 0; i--)
            if (m_sq[i][47:32] == a) return {1'b1, m_sq[i][31:0]};
        for (int i = m_rq.size() - 1; i >= 0; i--)
            if (m_rq[i][47:32] == a) return {1'b1, m_rq[i][31:0]};
        return 33'd0;
    endfunction

    task automatic send(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_data = d;
        model_accept(a, d);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic rdchk(input logic [15:0] a, input string tag);
        logic [32:0] e;
        e = mlook(a);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
        chk(rd_ack === 1'b1 && rd_hit === e[32] && rd_data === e[31:0], tag,
            {30'd0, rd_ack, rd_hit, rd_data}, {30'd0, 1'b1, e});
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!in_ready || exp_seq.size() != 0 || exp_rnd.size() != 0) @(negedge clk);
    endtask

    // monitor: pop expected items as the design hands them over
    always @(negedge clk) begin
        logic [47:0] e;
        string t;
        if (rst_n && seq_valid && seq_ready) begin
            if (exp_seq.size() == 0) begin
                chk(1'b0, "R4 R6 R7 unexpected seq write", {16'd0, seq_addr, seq_data}, 64'd0);
            end else begin
                e = exp_seq.pop_front(); t = tag_seq.pop_front();
                chk({seq_addr, seq_data} === e, t, {16'd0, seq_addr, seq_data}, {16'd0, e});
            end
        end
        if (rst_n && rnd_valid && rnd_ready) begin
            if (exp_rnd.size() == 0) begin
                chk(1'b0, "R2 R5 unexpected rnd entry", {16'd0, rnd_addr, rnd_data}, 64'd0);
            end else begin
                e = exp_rnd.pop_front(); t = tag_rnd.pop_front();
                chk({rnd_addr, rnd_data} === e, t, {16'd0, rnd_addr, rnd_data}, {16'd0, e});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL R8 watchdog act=hung exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(in_ready === 1'b1 && seq_valid === 1'b0 && rnd_valid === 1'b0 && rd_ack === 1'b0,
            "R1 reset outputs", {60'd0, in_ready, seq_valid, rnd_valid, rd_ack}, 64'h8);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 first page only loads
        send(16'd100, 32'hA0000100);
        repeat (3) @(negedge clk);
        chk(seq_valid === 1'b0 && rnd_valid === 1'b0 && in_ready === 1'b1, "R1 first page silent",
            {61'd0, seq_valid, rnd_valid, in_ready}, 64'd1);

        // R2 random batch at 4 channels
        send(16'd300, 32'hA0000300);
        send(16'd500, 32'hA0000500);
        send(16'd700, 32'hA0000700);
        chk(rnd_valid === 1'b0, "R2 below threshold", {63'd0, rnd_valid}, 64'd0);
        send(16'd900, 32'hA0000900);
        chk(rnd_valid === 1'b1, "R2 batch at threshold", {63'd0, rnd_valid}, 64'd1);
        wait_idle();
        rdchk(16'd900, "R9 hit holding register");
        rdchk(16'd300, "R9 miss after dispatch");

        // R3 R4 R6 R7 sequential run
        for (int i = 0; i < 8; i++) send(16'd1000 + 16'(i), 32'hB0000000 + 32'(i));
        rdchk(16'd1003, "R9 hit sequential buffer");
        send(16'd1008, 32'hB0000008);
        chk(in_ready === 1'b0 && seq_valid === 1'b1, "R8 intake stalls during flush",
            {62'd0, in_ready, seq_valid}, 64'd1);
        for (int i = 9; i < 13; i++) send(16'd1000 + 16'(i), 32'hB0000000 + 32'(i));
        send(16'd5000, 32'hC0005000);
        wait_idle();

        // R5 short run breaks in Judge mode
        send(16'd6000, 32'hC0006000);
        send(16'd6001, 32'hC0006001);
        send(16'd6002, 32'hC0006002);
        send(16'd7000, 32'hC0007000);
        wait_idle();

        // R10 clamping of the channel count
        chan_count = 4'd0;
        send(16'd8000, 32'hD0008000);
        chk(rnd_valid === 1'b1, "R10 zero channels acts as one", {63'd0, rnd_valid}, 64'd1);
        wait_idle();
        chan_count = 4'd15;
        for (int i = 0; i < 7; i++) send(16'd9000 + 16'(2 * i), 32'hD0009000 + 32'(i));
        chk(rnd_valid === 1'b0, "R10 seven of eight held", {63'd0, rnd_valid}, 64'd0);
        send(16'd9100, 32'hD0009100);
        chk(rnd_valid === 1'b1, "R10 batch capped at depth", {63'd0, rnd_valid}, 64'd1);
        wait_idle();

        // R8 R11 back-pressure on the random port
        chan_count = 4'd2;
        send(16'd9300, 32'hE0009300);
        rnd_ready = 1'b0;
        send(16'd9500, 32'hE0009500);
        repeat (2) @(negedge clk);
        held = rnd_addr;
        chk(rnd_valid === 1'b1 && in_ready === 1'b0, "R8 stalled while dispatch pending",
            {62'd0, rnd_valid, in_ready}, 64'd2);
        repeat (3) @(negedge clk);
        chk(rnd_valid === 1'b1 && rnd_addr === held, "R11 entry held under back-pressure",
            {47'd0, rnd_valid, rnd_addr}, {47'd0, 1'b1, held});
        rnd_ready = 1'b1;
        wait_idle();

        // R9 newest duplicate, then R3 wrap-around and R5 mixed dispatch
        chan_count = 4'd8;
        send(16'h0A0A, 32'h11111111);
        send(16'h0B0B, 32'h22222222);
        send(16'h0A0A, 32'h33333333);
        send(16'h0C0C, 32'h44444444);
        send(16'h0D0D, 32'h55555555);
        rdchk(16'h0A0A, "R9 newest duplicate wins");
        rdchk(16'h7777, "R9 miss");
        send(16'hFFFF, 32'h66666666);
        send(16'h0000, 32'h77777777);
        chk(rnd_valid === 1'b0 && seq_valid === 1'b0, "R3 wrap counts as consecutive",
            {62'd0, rnd_valid, seq_valid}, 64'd0);
        send(16'h0123, 32'h88888888);
        wait_idle();

        repeat (4) @(negedge clk);
        chk(exp_seq.size() == 0 && exp_rnd.size() == 0, "R2 R4 all expected writes seen",
            64'(exp_seq.size() + exp_rnd.size()), 64'd0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule